// File: doc/BRIEF.md
# Half-Duplex Serial Flash SPI Master

This block is a small SPI master for a serial NOR boot flash. Software reaches it through a simple register bus. Each transfer moves between one and four bytes, set by a length field. Writing the data register sends the top bytes of the written word to the flash. Reading the data register returns the word that was last received and starts the next receive. A transfer either sends or receives, never both at once.

The serial clock is the system clock divided by a fixed parameter, and it runs in SPI mode 0. Two bits in the control register drive the two active-low chip-select pins directly, so software frames each flash command itself. A read-only ready bit tells software when the shifter is idle. Two configuration bits choose the byte order, one for sending and one for receiving.

Top module: `spi_flash_master`

## Requirements
- R1: After reset the control register (offset 0x08) reads 0xC8000000: both chip-select bits set, length 0, ready bit 27 set and select bit 24 clear. The configuration register (offset 0x00) reads 0. Both `csN` pins are high and `sclk` is low.
- R2: The configuration register keeps bit 28 (receive order) and bit 27 (send order) and reads 0 in all other bits. The control register keeps bits 31, 30, 29:28 and 24 as written. Its bit 27 always reads the ready state, whatever value is written to it.
- R3: From the cycle after a control write, `csN[0]` equals control bit 31 and `csN[1]` equals control bit 30. The pins are active low, and they change on no other event.
- R4: A transfer moves length+1 bytes, where length is control bits 29:28. So 0 gives one byte and 3 gives four bytes, which is (length+1)*8 rising edges on `sclk`.
- R5: A write to the data register (offset 0x0C) while ready launches a send. Ready reads 0 from the next cycle and reads 1 again exactly (length+1)*8*CLK_DIV cycles after the launch edge.
- R6: `sclk` is low whenever the block is idle. `mosi` changes only while `sclk` is low, so the flash samples it on the rising edge.
- R7: The payload is the top length+1 bytes of the written word, and each byte is sent most significant bit first. With send order bit 27 set, bits 31:24 go first and then the next lower bytes follow. With it clear, the lowest payload byte goes first. A one-byte transfer always sends bits 31:24.
- R8: A read of the data register while ready returns the last received word and launches a receive. In the new word the payload sits in the top length+1 bytes and every byte below it is 0. With receive order bit 28 set, the first received byte lands in bits 31:24. With it clear, it lands in the lowest payload byte.
- R9: During a receive, `mosi` stays low. A send leaves the received word unchanged.
- R10: A data write or read while a transfer is in progress is ignored: it launches nothing and does not disturb the transfer in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (a data read has a side effect) |
| regAddr | input | ADDR_W | Register byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from `regAddr` |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| csN | output | 2 | Chip selects, active low |

## Verification
The bench builds the block with CLK_DIV = 4. This gives a two-cycle half period, so the divider counter actually wraps inside each half period. A four-byte transfer then lasts 128 cycles, which keeps the exact ready-timing checks short. The bench uses ADDR_W = 4, which decodes all three offsets with no aliasing. A flash model in the bench captures `mosi` on rising `sclk` edges and presents `miso` bits on falling edges. With it, the bench covers lengths 1, 2 and 4 bytes in both byte orders, in both directions, and with data strobes that arrive while the block is busy.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NUM_BYTES = WORD_W / 8;

  localparam int unsigned CFG_OFS  = 'h0;
  localparam int unsigned CTL_OFS  = 'h8;
  localparam int unsigned DATA_OFS = 'hC;

  // bit positions that software decodes
  localparam int unsigned CFG_RX_ORDER = 28;
  localparam int unsigned CFG_TX_ORDER = 27;
  localparam int unsigned CTL_CS0      = 31;
  localparam int unsigned CTL_CS1      = 30;
  localparam int unsigned CTL_LEN_HI   = 29;
  localparam int unsigned CTL_LEN_LO   = 28;
  localparam int unsigned CTL_READY    = 27;
  localparam int unsigned CTL_SEL      = 24;

  typedef struct packed {
    logic load;    // launch: load shifter
    logic sample;  // sclk about to rise
    logic shift;   // sclk about to fall, more bits follow
    logic finish;  // sclk about to fall on the last bit
  } spiStrobe_t;

  // Arrange the payload so that the first stream byte sits in bits 31:24.
  function automatic logic [WORD_W-1:0] txArrange(input logic [WORD_W-1:0] word,
                                                  input logic [1:0] len,
                                                  input logic msbFirst);
    logic [WORD_W-1:0] res;
    int src;
    res = '0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (k <= int'(len)) begin
        src = msbFirst ? (NUM_BYTES - 1 - k) : (NUM_BYTES - 1 - int'(len) + k);
        res[(NUM_BYTES-1-k)*8 +: 8] = word[src*8 +: 8];
      end
    end
    return res;
  endfunction

  // Place received stream bytes (first byte highest in raw) into the word.
  function automatic logic [WORD_W-1:0] rxArrange(input logic [WORD_W-1:0] raw,
                                                  input logic [1:0] len,
                                                  input logic msbFirst);
    logic [WORD_W-1:0] res;
    int dst;
    res = '0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (k <= int'(len)) begin
        dst = msbFirst ? (NUM_BYTES - 1 - k) : (NUM_BYTES - 1 - int'(len) + k);
        res[dst*8 +: 8] = raw[(int'(len)-k)*8 +: 8];
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/sfm_regs.sv
module sfm_regs
  import sfm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  input  logic              busy,
  input  logic [WORD_W-1:0] rxWord,
  output logic              startTx,
  output logic              startRx,
  output logic [1:0]        lenSel,
  output logic              txMsb,
  output logic              rxMsb,
  output logic [1:0]        csN
);
  logic cs0Bit, cs1Bit, selBit;
  logic hitCfg, hitCtl, hitData;

  assign hitCfg  = (regAddr == ADDR_W'(CFG_OFS));
  assign hitCtl  = (regAddr == ADDR_W'(CTL_OFS));
  assign hitData = (regAddr == ADDR_W'(DATA_OFS));

  assign startTx = regWr && hitData && !busy;
  assign startRx = regRd && hitData && !busy && !regWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txMsb  <= 1'b0;
      rxMsb  <= 1'b0;
      cs0Bit <= 1'b1;
      cs1Bit <= 1'b1;
      lenSel <= 2'd0;
      selBit <= 1'b0;
    end else if (regWr) begin
      if (hitCfg) begin
        rxMsb <= regWdata[CFG_RX_ORDER];
        txMsb <= regWdata[CFG_TX_ORDER];
      end
      if (hitCtl) begin
        cs0Bit <= regWdata[CTL_CS0];
        cs1Bit <= regWdata[CTL_CS1];
        lenSel <= regWdata[CTL_LEN_HI:CTL_LEN_LO];
        selBit <= regWdata[CTL_SEL];
      end
    end
  end

  assign csN = {cs1Bit, cs0Bit};

  always_comb begin
    regRdata = '0;
    if (hitCfg) begin
      regRdata[CFG_RX_ORDER] = rxMsb;
      regRdata[CFG_TX_ORDER] = txMsb;
    end else if (hitCtl) begin
      regRdata[CTL_CS0]               = cs0Bit;
      regRdata[CTL_CS1]               = cs1Bit;
      regRdata[CTL_LEN_HI:CTL_LEN_LO] = lenSel;
      regRdata[CTL_READY]             = !busy;
      regRdata[CTL_SEL]               = selBit;
    end else if (hitData) begin
      regRdata = rxWord;
    end
  end
endmodule

// File: rtl/sfm_ctrl.sv
module sfm_ctrl
  import sfm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] lenSel,
  output spiStrobe_t stb,
  output logic       sclk,
  output logic       busy
);
  localparam int HALF  = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BIT_W = $clog2(WORD_W);

  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt, lastBit;
  logic             phase, tick, lastNow;

  assign tick    = busy && (divCnt == DIV_W'(HALF - 1));
  assign lastNow = (bitCnt == lastBit);

  always_comb begin
    stb.load   = start && !busy;
    stb.sample = tick && !phase;
    stb.shift  = tick && phase && !lastNow;
    stb.finish = tick && phase && lastNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      divCnt  <= '0;
      phase   <= 1'b0;
      bitCnt  <= '0;
      lastBit <= '0;
    end else if (stb.load) begin
      busy    <= 1'b1;
      divCnt  <= '0;
      phase   <= 1'b0;
      bitCnt  <= '0;
      lastBit <= {lenSel, 3'b111};
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        phase  <= !phase;
        if (phase) begin
          if (lastNow) busy <= 1'b0;
          else         bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign sclk = phase;
endmodule

// File: rtl/sfm_datapath.sv
module sfm_datapath
  import sfm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        stb,
  input  logic              isRx,
  input  logic [1:0]        lenSel,
  input  logic              txMsb,
  input  logic              rxMsb,
  input  logic [WORD_W-1:0] txWord,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxWord
);
  logic [WORD_W-1:0] shReg;
  logic              rxMode, rxMsbQ;
  logic [1:0]        lenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      rxMode <= 1'b0;
      rxMsbQ <= 1'b0;
      lenQ   <= 2'd0;
      rxWord <= '0;
    end else begin
      if (stb.load) begin
        rxMode <= isRx;
        rxMsbQ <= rxMsb;
        lenQ   <= lenSel;
        shReg  <= isRx ? '0 : txArrange(txWord, lenSel, txMsb);
      end else if (stb.sample && rxMode) begin
        shReg <= {shReg[WORD_W-2:0], miso};
      end else if (stb.shift && !rxMode) begin
        shReg <= {shReg[WORD_W-2:0], 1'b0};
      end
      if (stb.finish && rxMode) begin
        rxWord <= rxArrange(shReg, lenQ, rxMsbQ);
      end
    end
  end

  assign mosi = !rxMode && shReg[WORD_W-1];
endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master
  import sfm_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [1:0]        csN
);
  spiStrobe_t        stb;
  logic              busy, startTx, startRx, txMsb, rxMsb;
  logic [1:0]        lenSel;
  logic [WORD_W-1:0] rxWord;

  sfm_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .rxWord(rxWord),
    .startTx(startTx), .startRx(startRx), .lenSel(lenSel), .txMsb(txMsb),
    .rxMsb(rxMsb), .csN(csN)
  );

  sfm_ctrl #(.CLK_DIV(CLK_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(startTx || startRx), .lenSel(lenSel),
    .stb(stb), .sclk(sclk), .busy(busy)
  );

  sfm_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .isRx(startRx), .lenSel(lenSel),
    .txMsb(txMsb), .rxMsb(rxMsb), .txWord(regWdata), .miso(miso),
    .mosi(mosi), .rxWord(rxWord)
  );
endmodule

// File: rtl/sfm_chk.sv
module sfm_chk #(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic              busy,
  input logic              sclk,
  input logic              mosi,
  input logic [1:0]        csN
);
  localparam int BOUND = 32 * CLK_DIV;
  logic [31:0] busyCycles;
  logic        ctlWr, dataWr;

  assign ctlWr  = regWr && (regAddr == ADDR_W'('h8));
  assign dataWr = regWr && (regAddr == ADDR_W'('hC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCycles <= '0;
    else if (busy) busyCycles <= busyCycles + 1;
    else           busyCycles <= '0;
  end

  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN) !busy |-> !sclk);
  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R5
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !busy) |=> busy);
  // R3
  cs_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> (csN == {$past(regWdata[30]), $past(regWdata[31])}));
  // R3
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWr |=> $stable(csN));
  // R4
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCycles < BOUND));
endmodule

bind spi_flash_master sfm_chk #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
  .busy(busy), .sclk(sclk), .mosi(mosi), .csN(csN)
);

// File: tb/spi_flash_master_tb_top.sv
module spi_flash_master_tb_top;
  localparam int CLK_DIV = 4;
  localparam int ADDR_W  = 4;
  localparam logic [3:0] A_CFG = 4'h0, A_CTL = 4'h8, A_DATA = 4'hC;

  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0, regRd = 1'b0;
  logic [ADDR_W-1:0] regAddr = A_CTL;
  logic [31:0] regWdata = '0, regRdata;
  logic sclk, mosi, miso;
  logic [1:0] csN;

  int checks = 0, errors = 0;
  bit done = 0;

  // flash model
  logic [31:0] slaveIn = '0;
  logic [31:0] pattern = '0;
  int riseCnt = 0, fallCnt = 0, fallBase = 0;
  int misoIdx;

  always #2 clk = ~clk;

  spi_flash_master #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN)
  );

  always @(posedge sclk) begin
    slaveIn = {slaveIn[30:0], mosi};
    riseCnt = riseCnt + 1;
  end
  always @(negedge sclk) fallCnt = fallCnt + 1;
  assign misoIdx = fallCnt - fallBase;
  assign miso = (misoIdx >= 0 && misoIdx < 32) ? pattern[31 - misoIdx] : 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regAddr = A_CTL;
    #1;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0; regAddr = A_CTL;
    #1;
  endtask

  task automatic waitReady(output int cyc);
    cyc = 0;
    regAddr = A_CTL;
    #0;
    while (regRdata[27] == 1'b0 && cyc < 2000) begin
      cyc++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    busRead(A_CTL, v);
    check(v == 32'hC800_0000, "R1 ctl reset", v, 32'hC800_0000);
    busRead(A_CFG, v);
    check(v == 32'h0, "R1 cfg reset", v, 32'h0);
    check(csN == 2'b11 && sclk == 1'b0, "R1 pins", {29'd0, csN, sclk}, 32'h6);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    busWrite(A_CFG, 32'hFFFF_FFFF);
    busRead(A_CFG, v);
    check(v == 32'h1800_0000, "R2 cfg fields", v, 32'h1800_0000);
    busWrite(A_CTL, 32'h3100_0000);
    busRead(A_CTL, v);
    check(v == 32'h3900_0000, "R2 ctl fields and ready", v, 32'h3900_0000);
    check(csN == 2'b00, "R3 both selects asserted", {30'd0, csN}, 32'h0);
    busWrite(A_CTL, 32'h8000_0000);
    check(csN == 2'b01, "R3 cs1 asserted only", {30'd0, csN}, 32'h1);
    busRead(A_CTL, v);
    check(v == 32'h8800_0000, "R2 ctl readback", v, 32'h8800_0000);
  endtask

  task automatic t_tx(input logic [1:0] len, input bit msb, input logic [31:0] word,
                      input logic [31:0] exp);
    int cyc, rb, nb;
    logic [31:0] mask;
    nb = (int'(len) + 1) * 8;
    mask = (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 1);
    busWrite(A_CFG, msb ? 32'h1800_0000 : 32'h0);
    busWrite(A_CTL, {2'b01, len, 28'h0});
    rb = riseCnt;
    busWrite(A_DATA, word);
    check(regRdata[27] == 1'b0, "R5 ready low after launch", regRdata, 32'h0);
    waitReady(cyc);
    check(cyc == nb * CLK_DIV, "R5 ready timing", cyc, nb * CLK_DIV);
    check(riseCnt - rb == nb, "R4 edge count", riseCnt - rb, nb);
    check((slaveIn & mask) == exp, "R7 sent bits", slaveIn & mask, exp);
  endtask

  task automatic t_rx(input logic [1:0] len, input bit msb, input logic [31:0] pat,
                      input logic [31:0] exp);
    int cyc, nb;
    logic [31:0] v;
    nb = (int'(len) + 1) * 8;
    busWrite(A_CFG, msb ? 32'h1800_0000 : 32'h0);
    busWrite(A_CTL, {2'b01, len, 28'h0});
    pattern = pat;
    fallBase = fallCnt;
    busRead(A_DATA, v);
    waitReady(cyc);
    check(cyc == nb * CLK_DIV, "R8 receive timing", cyc, nb * CLK_DIV);
    busRead(A_DATA, v);
    check(v == exp, "R8 received word", v, exp);
    pattern = '0;
    waitReady(cyc);
  endtask

  task automatic t_halfDuplex();
    int cyc;
    logic [31:0] v;
    busWrite(A_CFG, 32'h1800_0000);
    busWrite(A_CTL, 32'h7000_0000);
    pattern = 32'h5A5A_5A5A;
    fallBase = fallCnt;
    slaveIn = 32'hFFFF_FFFF;
    busRead(A_DATA, v);
    waitReady(cyc);
    check(slaveIn == 32'h0, "R9 mosi low in receive", slaveIn, 32'h0);
    pattern = '0;
    t_tx(2'd0, 1'b1, 32'h9900_0000, 32'h99);
    busRead(A_DATA, v);
    check(v == 32'h5A5A_5A5A, "R9 send keeps rx word", v, 32'h5A5A_5A5A);
    waitReady(cyc);
  endtask

  task automatic t_busy();
    int cyc, rb;
    logic [31:0] v;
    busWrite(A_CFG, 32'h1800_0000);
    busWrite(A_CTL, 32'h7000_0000);
    rb = riseCnt;
    busWrite(A_DATA, 32'h1122_3344);
    repeat (10) @(negedge clk);
    busWrite(A_DATA, 32'hFFFF_FFFF);
    busRead(A_DATA, v);
    waitReady(cyc);
    check(slaveIn == 32'h1122_3344, "R10 transfer undisturbed", slaveIn, 32'h1122_3344);
    repeat (20) @(negedge clk);
    #1;
    check(regRdata[27] == 1'b1, "R10 no relaunch", regRdata, 32'h0800_0000);
    check(riseCnt - rb == 32, "R10 edge count", riseCnt - rb, 32);
    check(sclk == 1'b0, "R6 sclk idle low", {31'd0, sclk}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    t_regs();
    t_tx(2'd0, 1'b1, 32'hA512_3456, 32'hA5);
    t_tx(2'd0, 1'b0, 32'h3C00_00FF, 32'h3C);
    t_tx(2'd3, 1'b1, 32'h1234_5678, 32'h1234_5678);
    t_tx(2'd3, 1'b0, 32'h1234_5678, 32'h7856_3412);
    t_tx(2'd1, 1'b0, 32'hABCD_1111, 32'hCDAB);
    t_rx(2'd3, 1'b1, 32'hCAFE_BABE, 32'hCAFE_BABE);
    t_rx(2'd3, 1'b0, 32'hCAFE_BABE, 32'hBEBA_FECA);
    t_rx(2'd0, 1'b1, 32'h3C00_0000, 32'h3C00_0000);
    t_rx(2'd1, 1'b0, 32'hABCD_0000, 32'hCDAB_0000);
    t_halfDuplex();
    t_busy();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule